// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches an already synchronised serial receive line and recognises a break: the line held low for longer than a chosen number of character-times. It advances only on the cycles where the 16x oversample enable is high, so every count it keeps is in oversample ticks. A character-time is ten bit-times when parity is off and eleven when it is on. Each bit-time is sixteen ticks. A two-bit selector picks a threshold of 2, 4, 8 or 16 character-times.

There are two outputs. A live status level rises when a break is recognised. A one-clock event pulse marks the same moment. Only one event is produced per break. The detector re-arms, and the status drops, once the line has been seen high on eight consecutive ticks, which is half a bit-time. While a break continues after its event, the status stays high even if a downstream interrupt has already been handled. Interrupt state and its clearing are kept outside this block.

Top module: `lineBreakDetect`

## Requirements
- R1: After reset, `breakActive` and `breakEvent` are both 0 and the detector is armed.
- R2: The threshold T in ticks is C × 16 × 2^(levelSel+1), where C is 10 when `parityEn` is 0 and 11 when it is 1. For example, levelSel=0 with parity off gives T=320, and levelSel=3 with parity on gives T=2816. When armed, `breakEvent` is 1 during exactly the one clock cycle that follows the tick cycle on which the line is sampled low for the (T+1)-th consecutive time.
- R3: A low run of exactly T ticks that is followed by a high tick produces no event and does not set `breakActive`.
- R4: `breakActive` becomes 1 in the same cycle as `breakEvent`. It stays 1 for as long as the line stays low.
- R5: Only one event is produced per break. No further event occurs while the line stays low. No further event occurs after a high period of fewer than 8 ticks followed by another low run longer than T.
- R6: The detector re-arms after 8 consecutive high ticks, and `breakActive` returns to 0 in the cycle after the 8th high tick. Seven high ticks are not enough. Once re-armed, a new low run longer than T produces a new event.
- R7: On cycles with `tick` at 0, `rxLevel` is ignored: no count changes, no event occurs and `breakActive` holds.
- R8: Any tick that samples the line high restarts the count of consecutive low ticks from zero.
- R9: If `levelSel` is changed during a low run to a threshold already below the current low count, an armed detector fires on the next low tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversample enable, one cycle per tick |
| rxLevel | input | 1 | Synchronised receive line level |
| parityEn | input | 1 | 1 selects 11-bit characters, 0 selects 10-bit characters |
| levelSel | input | 2 | Threshold select: 2^(levelSel+1) character-times |
| breakActive | output | 1 | Live break status level |
| breakEvent | output | 1 | One-cycle pulse, one per break |

## Verification
The bench sweeps all eight threshold and parity combinations. It checks the exact tick of the event at T+1 and checks that a low run of exactly T ticks does not fire. A comparison of greater-or-equal against greater-than, or a threshold that ignores parity, would move the event by one tick or by a whole character span. It drives seven and eight high ticks between low runs to catch a re-arm window that is off by one. A detector that re-arms on any high sample would emit a second event at that point. It gaps the ticks with idle cycles that carry a high line, which catches logic that samples without the enable. It also lowers the threshold in the middle of a long low run, which exposes an equality compare that never fires.

// File: rtl/lineBreakPkg.sv
package lineBreakPkg;
  localparam int TICKS_PER_BIT   = 16;
  localparam int REARM_TICKS     = 8;
  localparam int CHAR_BITS_PLAIN = 10;
  localparam int CHAR_BITS_PAR   = 11;
  localparam int SEL_W           = 2;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic lowInc;
    logic lowClr;
    logic highInc;
    logic highClr;
  } brkStrobe_t;
endpackage

// File: rtl/lineBreakDatapath.sv
module lineBreakDatapath
  import lineBreakPkg::*;
#(
  parameter int TPB      = TICKS_PER_BIT,
  parameter int CB_PLAIN = CHAR_BITS_PLAIN,
  parameter int CB_PAR   = CHAR_BITS_PAR,
  parameter int REARM    = REARM_TICKS,
  parameter int SELW     = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            parityEn,
  input  logic [SELW-1:0] levelSel,
  input  brkStrobe_t      strb,
  output logic            lowReached,
  output logic            highReached
);
  localparam int MAX_SHIFT = 1 << SELW;
  localparam int MAX_THR   = (CB_PAR * TPB) << MAX_SHIFT;
  localparam int LOW_W     = $clog2(MAX_THR + 2);
  localparam int HIGH_W    = $clog2(REARM + 1);
  localparam logic [LOW_W-1:0]  PLAIN_TICKS = LOW_W'(CB_PLAIN * TPB);
  localparam logic [LOW_W-1:0]  PAR_TICKS   = LOW_W'(CB_PAR * TPB);
  localparam logic [HIGH_W-1:0] HIGH_LAST   = HIGH_W'(REARM - 1);
  localparam logic [HIGH_W-1:0] HIGH_SAT    = HIGH_W'(REARM);

  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;
  logic [LOW_W-1:0]  charTicks;
  logic [LOW_W-1:0]  threshold;

  always_comb begin
    charTicks = parityEn ? PAR_TICKS : PLAIN_TICKS;
    threshold = charTicks << (int'(levelSel) + 1);
  end

  // Consecutive low ticks, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strb.lowClr) begin
      lowCnt <= '0;
    end else if (strb.lowInc && (lowCnt != '1)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // Consecutive high ticks, saturating at the re-arm span.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (strb.highClr) begin
      highCnt <= '0;
    end else if (strb.highInc && (highCnt != HIGH_SAT)) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign lowReached  = (lowCnt >= threshold);
  assign highReached = (highCnt == HIGH_LAST);
endmodule

// File: rtl/lineBreakControl.sv
module lineBreakControl
  import lineBreakPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxLevel,
  input  logic       lowReached,
  input  logic       highReached,
  output brkStrobe_t strb,
  output logic       breakActive,
  output logic       breakEvent
);
  logic armed;
  logic fireNow;
  logic rearmNow;

  always_comb begin
    strb         = '0;
    strb.lowInc  = tick && !rxLevel;
    strb.highClr = tick && !rxLevel;
    strb.lowClr  = tick && rxLevel;
    strb.highInc = tick && rxLevel;
    fireNow      = tick && !rxLevel && armed && lowReached;
    rearmNow     = tick && rxLevel && highReached;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed       <= 1'b1;
      breakActive <= 1'b0;
      breakEvent  <= 1'b0;
    end else begin
      breakEvent <= fireNow;
      if (fireNow) begin
        armed       <= 1'b0;
        breakActive <= 1'b1;
      end else if (rearmNow) begin
        armed       <= 1'b1;
        breakActive <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lineBreakDetect.sv
module lineBreakDetect
  import lineBreakPkg::*;
#(
  parameter int TPB      = TICKS_PER_BIT,
  parameter int CB_PLAIN = CHAR_BITS_PLAIN,
  parameter int CB_PAR   = CHAR_BITS_PAR,
  parameter int REARM    = REARM_TICKS,
  parameter int SELW     = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            rxLevel,
  input  logic            parityEn,
  input  logic [SELW-1:0] levelSel,
  output logic            breakActive,
  output logic            breakEvent
);
  brkStrobe_t strb;
  logic       lowReached;
  logic       highReached;

  lineBreakControl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .rxLevel     (rxLevel),
    .lowReached  (lowReached),
    .highReached (highReached),
    .strb        (strb),
    .breakActive (breakActive),
    .breakEvent  (breakEvent)
  );

  lineBreakDatapath #(
    .TPB      (TPB),
    .CB_PLAIN (CB_PLAIN),
    .CB_PAR   (CB_PAR),
    .REARM    (REARM),
    .SELW     (SELW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .parityEn    (parityEn),
    .levelSel    (levelSel),
    .strb        (strb),
    .lowReached  (lowReached),
    .highReached (highReached)
  );
endmodule

// File: rtl/lineBreakChecker.sv
module lineBreakChecker (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic rxLevel,
  input logic breakActive,
  input logic breakEvent
);
  // R2: the event lasts a single cycle
  a_r2_event_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    breakEvent |=> !breakEvent);

  // R4: the status is high whenever the event is
  a_r4_event_with_active: assert property (@(posedge clk) disable iff (!rstN)
    breakEvent |-> breakActive);

  // R5: the status only rises together with an event
  a_r5_rise_has_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakActive) |-> breakEvent);

  // R6: the status only falls after a tick that saw the line high
  a_r6_fall_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakActive) |-> $past(tick && rxLevel));

  // R7: nothing changes on cycles without a tick
  a_r7_idle_cycle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (!breakEvent && $stable(breakActive)));
endmodule

bind lineBreakDetect lineBreakChecker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .rxLevel     (rxLevel),
  .breakActive (breakActive),
  .breakEvent  (breakEvent)
);

// File: tb/test_lineBreakDetect.sv
module test_lineBreakDetect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxLevel = 1'b1;
  logic       parityEn = 1'b0;
  logic [1:0] levelSel = 2'd0;
  logic       breakActive;
  logic       breakEvent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lineBreakDetect i_lineBreakDetect (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .rxLevel     (rxLevel),
    .parityEn    (parityEn),
    .levelSel    (levelSel),
    .breakActive (breakActive),
    .breakEvent  (breakEvent)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic expectOut(input string req, input bit expAct, input bit expEv);
    check(breakActive == expAct, {req, " breakActive"}, breakActive, expAct);
    check(breakEvent == expEv, {req, " breakEvent"}, breakEvent, expEv);
  endtask

  // Called at a negedge: apply inputs, return at the next negedge.
  task automatic step(input bit rx, input bit tk);
    rxLevel = rx;
    tick    = tk;
    @(negedge clk);
  endtask

  function automatic int thr(input bit par, input int sel);
    return (par ? 11 : 10) * 16 * (2 << sel);
  endfunction

  task automatic highRun(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 1'b1);
  endtask

  task automatic sweepConfig(input bit par, input int sel);
    int t;
    t = thr(par, sel);
    parityEn = par;
    levelSel = 2'(sel);
    highRun(10);
    expectOut("R6 idle", 1'b0, 1'b0);
    // R3: exactly T low ticks must not fire
    for (int k = 1; k <= t; k++) begin
      step(1'b0, 1'b1);
      if (k == t) expectOut("R3 at T", 1'b0, 1'b0);
      else if (breakEvent) check(1'b0, "R3 early event", 1, 0);
    end
    step(1'b1, 1'b1);
    expectOut("R3 after high", 1'b0, 1'b0);
    // R2/R8: fresh run needs T+1 lows
    for (int k = 1; k <= t + 1; k++) begin
      step(1'b0, 1'b1);
      if (k >= t) expectOut("R2 R8 edge", k == t + 1, k == t + 1);
      else if (breakEvent || breakActive) check(1'b0, "R8 early fire", 1, 0);
    end
    // R4/R5: still low, single event
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b1);
      expectOut("R4 R5 hold low", 1'b1, 1'b0);
    end
    // R6: seven highs do not re-arm
    for (int k = 1; k <= 7; k++) begin
      step(1'b1, 1'b1);
      expectOut("R6 short high", 1'b1, 1'b0);
    end
    for (int k = 1; k <= t + 5; k++) begin
      step(1'b0, 1'b1);
      if (breakEvent) check(1'b0, "R5 second event", 1, 0);
    end
    expectOut("R5 no rearm", 1'b1, 1'b0);
    // R6: eight highs re-arm and clear the status
    for (int k = 1; k <= 8; k++) begin
      step(1'b1, 1'b1);
      expectOut("R6 rearm", k < 8, 1'b0);
    end
    for (int k = 1; k <= t + 1; k++) begin
      step(1'b0, 1'b1);
      if (k >= t) expectOut("R6 new break", k == t + 1, k == t + 1);
    end
    highRun(8);
    expectOut("R6 end", 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    expectOut("R1 in reset", 1'b0, 1'b0);
    rstN = 1'b1;
    step(1'b1, 1'b0);
    expectOut("R1 after reset", 1'b0, 1'b0);

    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++)
        sweepConfig(p[0], s);

    // R7: gapped ticks, idle cycles carry a high line
    parityEn = 1'b0;
    levelSel = 2'd0;
    t = thr(1'b0, 0);
    for (int k = 1; k <= t + 1; k++) begin
      step(1'b0, 1'b1);
      if (k == t + 1) expectOut("R7 tick fire", 1'b1, 1'b1);
      else if (breakEvent) check(1'b0, "R7 early", 1, 0);
      step(1'b1, 1'b0);
      expectOut("R7 idle cycle", k == t + 1, 1'b0);
    end
    highRun(8);
    expectOut("R7 rearm", 1'b0, 1'b0);

    // R9: lower the threshold mid-run
    levelSel = 2'd3;
    for (int k = 0; k < 400; k++) step(1'b0, 1'b1);
    expectOut("R9 before change", 1'b0, 1'b0);
    levelSel = 2'd0;
    step(1'b0, 1'b1);
    expectOut("R9 after change", 1'b1, 1'b1);
    step(1'b0, 1'b1);
    expectOut("R9 single", 1'b1, 1'b0);
    highRun(8);
    expectOut("R9 rearm", 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule